// File: doc/BRIEF.md
# Moving Inversions Memory Tester

A self-test engine that exercises a synchronous single-port RAM with a three-phase march. Each pass fills a chosen address window with a data pattern, from the bottom address upward. It then climbs the window again: it reads each word, checks it and overwrites it with the inverted pattern. Last it descends from the top address, reads each word, checks it against the inverted pattern and writes the true pattern back. Passes repeat until the chosen pattern family is used up.

Four pattern families are available. The solid family uses all-zero and all-one words. The byte family replicates a moving byte across the word. The two rotating families place a single one or a single zero at a bit position that steps with both the address and the pass number. Every mismatch produces a one-cycle error strobe that carries the address, the expected word and the word read back, and the test runs on. A start pulse begins a run, `busy` covers it and `done` marks its end.

Top module: `mem_march_bist`

## Requirements
- R1: A `start` pulse while idle begins a run in the next cycle. `busy` stays high for every cycle of the run. `done` is high for exactly one cycle, the cycle after the last RAM access, when `busy` is already low.
- R2: Each pass begins with a fill phase: one write per cycle of the pass pattern, to every address from `lo_addr` up to `hi_addr`.
- R3: The ascending sweep then visits `lo_addr` to `hi_addr`. At each address it spends one cycle on a read (`mem_en`=1, `mem_we`=0) and the next cycle on a write of the inverted pattern to the same address.
- R4: The descending sweep then visits `hi_addr` down to `lo_addr`, read then write. The word written is the pass pattern, so the RAM ends each pass holding the pattern.
- R5: Read data is taken one cycle after the read is issued, in the same cycle as the write to that address. A pass over N words therefore takes exactly 5N cycles.
- R6: Mode code 0 (solid) runs 2 passes: pass 0 uses all zeros and pass 1 uses all ones.
- R7: Mode code 1 (byte) runs 20 passes, with the byte replicated in every byte lane. Passes 0-7 use byte 1<<p. Passes 8-15 use the inverse of 1<<(p-8). Passes 16-19 use 8'h03<<(2(p-16)).
- R8: Mode code 2 (rotating one) runs DW passes. In pass p the word for address a has a single one at bit (a+p) mod DW.
- R9: Mode code 3 (rotating zero) runs DW passes, each word being the inverse of the R8 word.
- R10: A mismatch raises `err_valid` for one cycle, in the cycle after the compare. `err_addr`, `exp_data` and `got_data` carry the address, the expected word (the pattern in the ascending sweep, its inverse in the descending sweep) and the word read. The run carries on with no change to its access sequence.
- R11: Mode and window are sampled at the accepted `start`. Later changes to them, and `start` pulses during a run, have no effect on the run.
- R12: Accesses stay within [`lo_addr`, `hi_addr`] (with `lo_addr` <= `hi_addr`). Words outside the window keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, taken only while idle |
| mode | input | 2 | Pattern family: 0 solid, 1 byte, 2 rotating one, 3 rotating zero |
| lo_addr | input | AW | Lowest address of the window |
| hi_addr | input | AW | Highest address of the window |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable (read when low) |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_rdata | input | DW | RAM read data, valid one cycle after a read |
| err_valid | output | 1 | One-cycle mismatch strobe |
| err_addr | output | AW | Address of the mismatch |
| exp_data | output | DW | Expected word |
| got_data | output | DW | Word read back |

## Verification
The bench builds the engine with AW=5 and DW=32, so a 32-word RAM covers the whole address space. The bench then follows every single access of each run, with every pass of all four pattern families: full windows, an inner window and one-word windows. At the small address width all 32 rotating passes take only a few thousand cycles. The RAM model corrupts reads at one chosen address, so every error report can be predicted and checked, and the words outside the window can be checked for change.

// File: rtl/mem_march_bist.sv
module mem_march_bist #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] exp_data,
  output logic [DW-1:0] got_data
);
  localparam int LW = $clog2(DW);
  localparam int PW = (LW > 5) ? LW : 5;
  localparam int SW = AW + PW + 1;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_UPR, S_UPW, S_DNR, S_DNW} st_t;

  st_t           st;
  logic [AW-1:0] addr, lo_q, hi_q;
  logic [1:0]    mode_q;
  logic [PW-1:0] pass, last;
  logic [7:0]    byte_p;
  logic [SW-1:0] rsum;
  logic [LW-1:0] rpos;
  logic [DW-1:0] pat, chk;

  always_comb begin
    if (pass < PW'(8))       byte_p = 8'd1 << pass[2:0];
    else if (pass < PW'(16)) byte_p = ~(8'd1 << pass[2:0]);
    else                     byte_p = 8'h03 << {pass[1:0], 1'b0};
  end

  assign rsum = SW'(addr) + SW'(pass);
  assign rpos = LW'(rsum % SW'(DW));

  always_comb begin
    case (mode_q)
      2'd0:    pat = {DW{pass[0]}};
      2'd1:    pat = {(DW/8){byte_p}};
      2'd2:    pat = DW'(1) << rpos;
      default: pat = ~(DW'(1) << rpos);
    endcase
    case (mode_q)
      2'd0:    last = PW'(1);
      2'd1:    last = PW'(19);
      default: last = PW'(DW - 1);
    endcase
  end

  assign chk       = (st == S_UPW) ? pat : ~pat;
  assign busy      = (st != S_IDLE);
  assign mem_en    = busy;
  assign mem_we    = (st == S_FILL) || (st == S_UPW) || (st == S_DNW);
  assign mem_addr  = addr;
  assign mem_wdata = (st == S_UPW) ? ~pat : pat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      mode_q <= '0;
      pass   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          lo_q   <= lo_addr;
          hi_q   <= hi_addr;
          mode_q <= mode;
          addr   <= lo_addr;
          pass   <= '0;
          st     <= S_FILL;
        end
        S_FILL: if (addr == hi_q) begin
          addr <= lo_q;
          st   <= S_UPR;
        end else addr <= addr + 1'b1;
        S_UPR: st <= S_UPW;
        S_UPW: if (addr == hi_q) st <= S_DNR;
               else begin
                 addr <= addr + 1'b1;
                 st   <= S_UPR;
               end
        S_DNR: st <= S_DNW;
        S_DNW: if (addr != lo_q) begin
          addr <= addr - 1'b1;
          st   <= S_DNR;
        end else if (pass == last) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end else begin
          pass <= pass + 1'b1;
          st   <= S_FILL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_addr  <= '0;
      exp_data  <= '0;
      got_data  <= '0;
    end else begin
      err_valid <= 1'b0;
      if (((st == S_UPW) || (st == S_DNW)) && (mem_rdata != chk)) begin
        err_valid <= 1'b1;
        err_addr  <= addr;
        exp_data  <= chk;
        got_data  <= mem_rdata;
      end
    end
  end
endmodule

module mem_march_bist_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          err_valid,
  input logic [AW-1:0] err_addr,
  input logic [1:0]    mode_q,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (mem_en && mem_we && $stable(mem_addr)));
  // R10
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> ($past(mem_en) && $past(mem_we) && err_addr == $past(mem_addr)));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || ($stable(mode_q) && $stable(lo_q) && $stable(hi_q))));
  // R12
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr >= lo_q && mem_addr <= hi_q));
endmodule

bind mem_march_bist mem_march_bist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .err_valid(err_valid),
  .err_addr(err_addr), .mode_q(mode_q), .lo_q(lo_q), .hi_q(hi_q)
);

// File: tb/sim_mem_march_bist.sv
`timescale 1ns/1ps
module sim_mem_march_bist;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic busy, done, mem_en, mem_we, err_valid;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, exp_data, got_data;

  always #2 clk = ~clk;

  mem_march_bist #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .lo_addr(lo_addr),
    .hi_addr(hi_addr), .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .err_valid(err_valid), .err_addr(err_addr), .exp_data(exp_data), .got_data(got_data));

  logic [DW-1:0] ram [NW];
  logic          preload = 1'b0;
  int            fault_addr = -1;
  logic [DW-1:0] fault_mask = '0;

  always @(posedge clk) begin
    if (preload) begin
      for (int i = 0; i < NW; i++) ram[i] <= 32'hDEAD0000 | i;
    end else if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr] ^ ((int'(mem_addr) == fault_addr) ? fault_mask : '0);
    end
  end

  int nerr = 0;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_exp, e_got;
  always @(negedge clk) begin
    if (rst_n && err_valid) begin
      if (nerr == 0) begin
        e_addr = err_addr; e_exp = exp_data; e_got = got_data;
      end
      nerr = nerr + 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int npass(input int m);
    return (m == 0) ? 2 : (m == 1) ? 20 : DW;
  endfunction

  function automatic logic [DW-1:0] bpat(input int m, input int p, input int a);
    logic [7:0] b;
    logic [DW-1:0] one;
    b = (p < 8) ? 8'(1 << p) : (p < 16) ? ~8'(1 << (p - 8)) : 8'(3 << (2 * (p - 16)));
    one = DW'(1) << ((a + p) % DW);
    case (m)
      0:       return (p == 1) ? '1 : '0;
      1:       return {4{b}};
      2:       return one;
      default: return ~one;
    endcase
  endfunction

  task automatic run(input int m, input int lo, input int hi, input int fa,
                     input logic [DW-1:0] fm, input bit poke);
    int n = hi - lo + 1;
    int bad = 0, idx = 0;
    string tag;
    logic [DW-1:0] ba, be;
    logic [DW-1:0] p;
    @(negedge clk);
    preload = 1'b1;
    @(negedge clk);
    preload = 1'b0;
    fault_addr = fa; fault_mask = fm; nerr = 0;
    mode = 2'(m); lo_addr = AW'(lo); hi_addr = AW'(hi); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    mode = 2'(m + 1); lo_addr = AW'(0); hi_addr = AW'(NW - 1);
    for (int ps = 0; ps < npass(m); ps++) begin
      for (int k = 0; k < 5 * n; k++) begin
        logic ew;
        int ea;
        if (k < n) begin
          ew = 1'b1; ea = lo + k; p = bpat(m, ps, ea);
        end else if (k < 3 * n) begin
          ea = lo + (k - n) / 2; ew = ((k - n) % 2) == 1; p = ~bpat(m, ps, ea);
        end else begin
          ea = hi - (k - 3 * n) / 2; ew = ((k - 3 * n) % 2) == 1; p = bpat(m, ps, ea);
        end
        if (!(busy && mem_en && mem_we == ew && int'(mem_addr) == ea &&
              (!ew || mem_wdata == p))) begin
          if (bad == 0) begin
            ba = {mem_en, mem_we, 30'(mem_addr)}; be = {1'b1, ew, 30'(ea)};
          end
          bad++;
        end
        start = (poke && idx == 7) ? 1'b1 : 1'b0;
        idx++;
        @(posedge clk);
        @(negedge clk);
      end
    end
    start = 1'b0;
    $sformat(tag, "mode %0d [%0d:%0d]", m, lo, hi);
    // R2 R3 R4 R5 R6 R7 R8 R9: exact access sequence, 5N cycles per pass; R11: config changes and pokes ignored
    chk(bad == 0, "R2/R3/R4/R5/R11", {tag, " access sequence"}, ba, be);
    // R1
    chk(done === 1'b1 && busy === 1'b0, "R1", {tag, " done at end"}, {done, busy}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    chk(done === 1'b0, "R1", {tag, " done one cycle"}, done, 0);
    bad = 0;
    for (int a = 0; a < NW; a++) begin
      p = (a >= lo && a <= hi) ? bpat(m, npass(m) - 1, a) : (32'hDEAD0000 | a);
      if (ram[a] !== p) bad++;
    end
    // R4 R12: window holds final pattern, outside untouched
    chk(bad == 0, "R4/R12", {tag, " final RAM contents"}, bad, 0);
    if (fa >= lo && fa <= hi) begin
      // R10
      chk(nerr == 2 * npass(m), "R10", {tag, " error count"}, nerr, 2 * npass(m));
      chk(e_addr == AW'(fa) && e_exp == bpat(m, 0, fa) && e_got == (bpat(m, 0, fa) ^ fm),
          "R10", {tag, " first error fields"}, e_got, bpat(m, 0, fa) ^ fm);
    end else begin
      chk(nerr == 0, "R10", {tag, " no errors"}, nerr, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_en && !err_valid, "R1", "reset state",
        {busy, done, mem_en, err_valid}, 0);
    run(0, 0, NW - 1, -1, '0, 1'b1);        // R6, R11
    run(1, 9, 9, 9, 32'h00000100, 1'b0);    // R7, R10
    run(2, 3, 17, 17, 32'h80000001, 1'b1);  // R8, R10
    run(3, 0, NW - 1, 0, 32'h1, 1'b0);      // R9, R10
    run(0, 30, 31, 30, '1, 1'b0);           // R6, R10, R12
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule